// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Self-Disabling Enables

The block gathers single-cycle event inputs from several functional blocks, plus a periodic one-second tick that it makes itself, and combines them into one registered, active-low interrupt request. Each functional block has its own latched status register and its own per-source enable register. A top-level enable register gates each block as a whole and also enables the one-second source. A top-level status register shows the one-second event and a read-only summary of each block.

A processor reaches the registers over a byte-wide bus with chip-select and separate read and write strobes. A small bus state machine handles each access. In `BUS_IDLE`, a selected read strobe moves it to `BUS_READ`: it captures a snapshot of the addressed register, which is returned on the read data port. A selected write strobe with no read moves it to `BUS_WRITE`: it commits the write once. `BUS_READ` returns to `BUS_IDLE` in the cycle the read strobe is seen low, and at that edge it clears the clear-on-read status bits that were set in the snapshot. `BUS_WRITE` returns to `BUS_IDLE` when the write strobe is seen low.

When the automatic-disable mode bit is set, a source that raises an interrupt has its enable bit cleared at that same edge. Software then re-arms the source when it is ready.

Top module: `irqc_top`

## Requirements
- R1: After reset, every register reads 00h, `irq_n` is 1 and `bus_rdata` is 00h.
- R2: Address 01h is an 8-bit read/write control register. Bit 0 is the automatic-disable mode bit.
- R3: The one-second tick fires once every `TICK_DIV` clock cycles. When top-enable bit 0 is 1, each tick sets top-status bit 0, so two consecutive requests fall exactly `TICK_DIV` cycles apart.
- R4: Reading address 05h clears top-status bit 0 at the edge where `BUS_READ` sees the read strobe low, and only if that bit was 1 in the snapshot. A tick that lands on that same edge leaves the bit at 1.
- R5: An event on source s of block b sets bit s of the block status register at 10h+2b, but only when bit s of that block's source enable is 1. Events on disabled sources are ignored. Block status is clear-on-read by snapshot, in the same way as R4.
- R6: The source enable register of block b sits at 11h+2b and is read/write on bits [NSRC-1:0]. Its higher bits read 0.
- R7: Address 04h is the top enable register. Bit 0 enables the one-second source and bit 1+b gates block b. A 0 in bit 1+b masks block b from `irq_n`. A 1 there does not enable that block's sources.
- R8: Top-status bit 1+b is the OR of block b's status bits. It is read-only, and reading it does not clear it.
- R9: `irq_n` is 0 exactly one cycle after the one-second status is set, or after any block has both a nonzero status and a 1 in its top enable bit. Otherwise it is 1.
- R10: With mode bit 0 set, an activating event clears the enable bit of its own source at the edge where it sets status. For the one-second source, this is top-enable bit 0. With the mode bit clear, enables are unchanged by activations. A bus write to the same register at that edge wins.
- R11: Each write strobe commits exactly once. A read strobe takes priority over a write strobe that arrives at the same time. Writes to read-only or unused addresses change nothing, and reads of unused addresses return 00h.
- R12: `bus_rdata` carries the snapshot from the cycle after the read strobe is seen and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Snapshot of the last read register |
| evt_in | input | NBLK*NSRC | Event inputs; source s of block b is bit b*NSRC+s |
| irq_n | output | 1 | Registered interrupt request, active low |

## Verification
A status bit that is wrongly latched or lost shows up on `irq_n` one cycle after the edge that mis-set it. It also shows in the next read snapshot. A misplaced clear shows in the same way one cycle after the read strobe is released. An enable bit that the automatic mode fails to clear stays hidden until a second event arrives or the enable register is read back, so the bench reads it back. A tick counter that is off by a few cycles only appears as a wrong spacing between requests, so the bench measures that spacing. A bench model running cycle by cycle compares `irq_n` and `bus_rdata` on every clock, so any divergence surfaces within one cycle of its cause.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_state_t;

    localparam logic [7:0] ADDR_CTRL     = 8'h01;
    localparam logic [7:0] ADDR_TOP_EN   = 8'h04;
    localparam logic [7:0] ADDR_TOP_ST   = 8'h05;
    localparam logic [7:0] ADDR_BLK_BASE = 8'h10;
    localparam int         AUTO_BIT      = 0;

    function automatic logic [7:0] blk_st_addr(input int b);
        return ADDR_BLK_BASE + 8'(2 * b);
    endfunction

    function automatic logic [7:0] blk_en_addr(input int b);
        return ADDR_BLK_BASE + 8'(2 * b + 1);
    endfunction

endpackage

// File: rtl/irqc_tick_gen.sv
module irqc_tick_gen #(
    parameter int unsigned DIV = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    if (DIV > 1) begin : g_gap
        // R3
        tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end

endmodule

// File: rtl/irqc_src_block.sv
module irqc_src_block #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            auto_mode,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_wdata,
    input  logic [NSRC-1:0] st_clr,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] enable
);
    logic [NSRC-1:0] act;

    assign act = evt & enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~st_clr) | act;
            if (en_we)
                enable <= en_wdata;
            else if (auto_mode)
                enable <= enable & ~act;
        end
    end

    // R5
    set_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|act) |=> ((status & $past(act)) == $past(act)));

    // R10
    auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !en_we && (|act)) |=> ((enable & $past(act)) == '0));

    // R10
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && !en_we) |=> (enable == $past(enable)));

endmodule

// File: rtl/irqc_bus_fsm.sv
module irqc_bus_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_cs,
    input  logic bus_rd,
    input  logic bus_wr,
    output logic rd_cap,
    output logic rd_done,
    output logic wr_go
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (bus_cs && bus_rd)      state_d = BUS_READ;
                else if (bus_cs && bus_wr) state_d = BUS_WRITE;
            end
            BUS_READ:  if (!bus_rd) state_d = BUS_IDLE;
            BUS_WRITE: if (!bus_wr) state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        rd_cap  = (state_q == BUS_IDLE) && bus_cs && bus_rd;
        wr_go   = (state_q == BUS_IDLE) && bus_cs && bus_wr && !bus_rd;
        rd_done = (state_q == BUS_READ) && !bus_rd;
    end

    // R11
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !wr_go);

    // R12
    read_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (state_q == BUS_IDLE));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int          NBLK     = 3,
    parameter int          NSRC     = 4,
    parameter int unsigned TICK_DIV = 1000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_cs,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic [NBLK*NSRC-1:0] evt_in,
    output logic                 irq_n
);
    localparam int TEW = NBLK + 1;

    logic            tick, rd_cap, rd_done, wr_go;
    logic [7:0]      ctrl_q, rdata_q, addr_q, rd_mux;
    logic [TEW-1:0]  top_en_q;
    logic            onesec_q, os_act, os_clr, auto_mode, pending;
    logic [NSRC-1:0] blk_st  [NBLK];
    logic [NSRC-1:0] blk_en  [NBLK];
    logic [NSRC-1:0] st_clr  [NBLK];
    logic [NBLK-1:0] blk_sum, en_we;

    irqc_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    irqc_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_cs (bus_cs),
        .bus_rd (bus_rd),
        .bus_wr (bus_wr),
        .rd_cap (rd_cap),
        .rd_done(rd_done),
        .wr_go  (wr_go)
    );

    assign auto_mode = ctrl_q[AUTO_BIT];

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        assign en_we[b]   = wr_go && (bus_addr == blk_en_addr(b));
        assign st_clr[b]  = (rd_done && (addr_q == blk_st_addr(b))) ? rdata_q[NSRC-1:0] : '0;
        assign blk_sum[b] = |blk_st[b];

        irqc_src_block #(.NSRC(NSRC)) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_in[b*NSRC +: NSRC]),
            .auto_mode(auto_mode),
            .en_we    (en_we[b]),
            .en_wdata (bus_wdata[NSRC-1:0]),
            .st_clr   (st_clr[b]),
            .status   (blk_st[b]),
            .enable   (blk_en[b])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_CTRL)
            rd_mux = ctrl_q;
        else if (bus_addr == ADDR_TOP_EN)
            rd_mux[TEW-1:0] = top_en_q;
        else if (bus_addr == ADDR_TOP_ST)
            rd_mux[TEW-1:0] = {blk_sum, onesec_q};
        else begin
            for (int b = 0; b < NBLK; b++) begin
                if (bus_addr == blk_st_addr(b)) rd_mux[NSRC-1:0] = blk_st[b];
                if (bus_addr == blk_en_addr(b)) rd_mux[NSRC-1:0] = blk_en[b];
            end
        end
    end

    assign os_act  = tick && top_en_q[0];
    assign os_clr  = rd_done && (addr_q == ADDR_TOP_ST) && rdata_q[0];
    assign pending = onesec_q || (|(blk_sum & top_en_q[TEW-1:1]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            top_en_q <= '0;
            onesec_q <= 1'b0;
            rdata_q  <= '0;
            addr_q   <= '0;
            irq_n    <= 1'b1;
        end else begin
            if (rd_cap) begin
                rdata_q <= rd_mux;
                addr_q  <= bus_addr;
            end
            if (wr_go && (bus_addr == ADDR_CTRL))
                ctrl_q <= bus_wdata;
            if (wr_go && (bus_addr == ADDR_TOP_EN))
                top_en_q <= bus_wdata[TEW-1:0];
            else if (auto_mode && os_act)
                top_en_q[0] <= 1'b0;
            onesec_q <= (onesec_q && !os_clr) || os_act;
            irq_n    <= !pending;
        end
    end

    assign bus_rdata = rdata_q;

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_n);

    // R4
    os_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (os_clr && !os_act) |=> !onesec_q);

    // R4
    os_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        os_act |=> onesec_q);

    // R10
    os_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && os_act && !(wr_go && (bus_addr == ADDR_TOP_EN))) |=> !top_en_q[0]);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(top_en_q[TEW-1:1]) == '0) && !$past(onesec_q)) |-> irq_n);

endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NBLK = 3;
    localparam int NSRC = 4;
    localparam int DIV  = 50;
    localparam int TEW  = NBLK + 1;
    localparam int SMASK = (1 << NSRC) - 1;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic [NBLK*NSRC-1:0] evt = '0;
    logic irq_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top #(.NBLK(NBLK), .NSRC(NSRC), .TICK_DIV(DIV)) u_irqc_top (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_rd(rd), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .evt_in(evt), .irq_n(irq_n)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt, m_st, m_snap, m_addr, m_ctrl, m_ten, m_os, m_irqn;
    int m_bst[NBLK];
    int m_ben[NBLK];
    int t_rv, t_pend, t_tick, t_cap, t_wgo, t_done, t_osact, t_act, t_clr;

    function automatic int model_read(input int a);
        int v = 0;
        if (a == 1) v = m_ctrl;
        else if (a == 4) v = m_ten;
        else if (a == 5) begin
            v = m_os;
            for (int b = 0; b < NBLK; b++) if (m_bst[b] != 0) v |= (1 << (b + 1));
        end else
            for (int b = 0; b < NBLK; b++) begin
                if (a == 16 + 2*b) v = m_bst[b];
                if (a == 17 + 2*b) v = m_ben[b];
            end
        return v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_st = 0; m_snap = 0; m_addr = 0; m_ctrl = 0; m_ten = 0; m_os = 0; m_irqn = 1;
            for (int b = 0; b < NBLK; b++) begin m_bst[b] = 0; m_ben[b] = 0; end
        end else begin
            t_rv   = model_read(int'(addr));
            t_pend = m_os;
            for (int b = 0; b < NBLK; b++)
                if (m_bst[b] != 0 && ((m_ten >> (b + 1)) & 1) == 1) t_pend = 1;
            t_tick  = (m_cnt == DIV - 1);
            t_cap   = (m_st == 0 && cs && rd);
            t_wgo   = (m_st == 0 && cs && wr && !rd);
            t_done  = (m_st == 1 && !rd);
            t_osact = t_tick && (m_ten & 1);
            if (t_done && m_addr == 5 && (m_snap & 1)) m_os = 0;
            if (t_osact) m_os = 1;
            for (int b = 0; b < NBLK; b++) begin
                t_act = int'((evt >> (b * NSRC))) & SMASK & m_ben[b];
                t_clr = (t_done && m_addr == 16 + 2*b) ? m_snap : 0;
                m_bst[b] = (m_bst[b] & ~t_clr) | t_act;
                if (t_wgo && int'(addr) == 17 + 2*b) m_ben[b] = int'(wdata) & SMASK;
                else if (m_ctrl & 1) m_ben[b] = m_ben[b] & ~t_act;
            end
            if (t_wgo && addr == 8'h04) m_ten = int'(wdata) & ((1 << TEW) - 1);
            else if ((m_ctrl & 1) && t_osact) m_ten = m_ten & ~1;
            if (t_wgo && addr == 8'h01) m_ctrl = int'(wdata);
            if (t_cap) begin m_snap = t_rv; m_addr = int'(addr); end
            if (m_st == 0) begin
                if (cs && rd) m_st = 1;
                else if (cs && wr) m_st = 2;
            end else if (m_st == 1) begin
                if (!rd) m_st = 0;
            end else if (!wr) m_st = 0;
            m_cnt  = t_tick ? 0 : m_cnt + 1;
            m_irqn = !t_pend;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R9 / R12: per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq_n == m_irqn[0], "R9 irq_n vs model", int'(irq_n), m_irqn);
            check(int'(rdata) == m_snap, "R12 rdata vs model", int'(rdata), m_snap);
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr = 0;
        @(negedge clk);
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1; rd = 1; addr = a;
        @(negedge clk); d = rdata; cs = 0; rd = 0;
        @(negedge clk);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); evt[idx] = 1'b1;
        @(negedge clk); evt[idx] = 1'b0;
    endtask

    task automatic wait_irq(output int at);
        at = -1;
        for (int i = 0; i < 4 * DIV; i++) begin
            @(negedge clk);
            if (!irq_n) begin at = cyc; break; end
        end
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        report();
    end

    initial begin
        logic [7:0] d;
        int t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check(irq_n == 1'b1, "R1 irq_n after reset", int'(irq_n), 1);
        check(rdata == 8'h00, "R1 rdata after reset", int'(rdata), 0);
        rd_reg(8'h01, d); check(d == 8'h00, "R1 ctrl reset", int'(d), 0);
        rd_reg(8'h04, d); check(d == 8'h00, "R1 top enable reset", int'(d), 0);
        rd_reg(8'h11, d); check(d == 8'h00, "R1 block enable reset", int'(d), 0);
        // R2 control register
        wr_reg(8'h01, 8'hA4); rd_reg(8'h01, d); check(d == 8'hA4, "R2 ctrl readback", int'(d), 'hA4);
        wr_reg(8'h01, 8'h00);
        // R6 source enable width
        wr_reg(8'h13, 8'hFB); rd_reg(8'h13, d); check(d == 8'h0B, "R6 enable readback", int'(d), 'h0B);
        wr_reg(8'h13, 8'h00);
        // R11 unused / read-only writes, read priority
        wr_reg(8'h30, 8'hFF); rd_reg(8'h30, d); check(d == 8'h00, "R11 unused addr", int'(d), 0);
        wr_reg(8'h05, 8'hFF); rd_reg(8'h05, d); check(d == 8'h00, "R8 top status read-only", int'(d), 0);
        @(negedge clk); cs = 1; rd = 1; wr = 1; addr = 8'h01; wdata = 8'h5A;
        @(negedge clk); cs = 0; rd = 0; wr = 0;
        @(negedge clk);
        rd_reg(8'h01, d); check(d == 8'h00, "R11 read beats write", int'(d), 0);
        // R3 ticks ignored while disabled
        repeat (2 * DIV) @(negedge clk);
        rd_reg(8'h05, d); check(d == 8'h00, "R3 disabled tick", int'(d), 0);
        check(irq_n == 1'b1, "R3 no request when disabled", int'(irq_n), 1);
        // R3 / R4 periodic request and clear-on-read
        wr_reg(8'h04, 8'h01);
        wait_irq(t1); check(t1 >= 0, "R3 first request", t1, 0);
        rd_reg(8'h05, d); check(d == 8'h01, "R4 one-second status", int'(d), 1);
        @(negedge clk); check(irq_n == 1'b1, "R4 request released", int'(irq_n), 1);
        wait_irq(t2); check(t2 - t1 == DIV, "R3 request spacing", t2 - t1, DIV);
        // R4 tick coincides with clearing edge
        @(negedge clk); cs = 1; rd = 1; addr = 8'h05;
        for (int i = 0; i < 2 * DIV; i++) begin
            @(negedge clk);
            if (m_cnt == DIV - 1) break;
        end
        cs = 0; rd = 0;
        @(negedge clk);
        rd_reg(8'h05, d); check(d == 8'h01, "R4 tick on clear edge kept", int'(d), 1);
        wr_reg(8'h04, 8'h00);
        rd_reg(8'h05, d);
        // R5 / R7 / R8 block path
        wr_reg(8'h13, 8'h04);
        pulse(1 * NSRC + 2);
        @(negedge clk);
        rd_reg(8'h05, d); check(d == 8'h04, "R8 block summary", int'(d), 4);
        check(irq_n == 1'b1, "R7 block masked", int'(irq_n), 1);
        rd_reg(8'h05, d); check(d == 8'h04, "R8 summary not cleared", int'(d), 4);
        wr_reg(8'h04, 8'h04);
        check(irq_n == 1'b0, "R9 block unmasked", int'(irq_n), 0);
        rd_reg(8'h12, d); check(d == 8'h04, "R5 block status", int'(d), 4);
        @(negedge clk); check(irq_n == 1'b1, "R5 cleared by read", int'(irq_n), 1);
        pulse(1 * NSRC + 0);
        @(negedge clk);
        rd_reg(8'h12, d); check(d == 8'h00, "R5 disabled source ignored", int'(d), 0);
        wr_reg(8'h04, 8'h0E);
        pulse(0);
        @(negedge clk);
        rd_reg(8'h10, d); check(d == 8'h00, "R7 block enable alone", int'(d), 0);
        check(irq_n == 1'b1, "R7 no request", int'(irq_n), 1);
        rd_reg(8'h11, d); check(d == 8'h00, "R7 sources stay off", int'(d), 0);
        // R10 automatic disable
        wr_reg(8'h01, 8'h01); wr_reg(8'h11, 8'h03);
        pulse(0);
        @(negedge clk);
        rd_reg(8'h11, d); check(d == 8'h02, "R10 auto cleared enable", int'(d), 2);
        rd_reg(8'h10, d); check(d == 8'h01, "R10 status latched", int'(d), 1);
        wr_reg(8'h01, 8'h00); wr_reg(8'h11, 8'h03);
        pulse(1);
        @(negedge clk);
        rd_reg(8'h11, d); check(d == 8'h03, "R10 enable kept", int'(d), 3);
        rd_reg(8'h10, d);
        wr_reg(8'h01, 8'h01); wr_reg(8'h04, 8'h01);
        wait_irq(t1);
        rd_reg(8'h04, d); check(d == 8'h00, "R10 one-second auto off", int'(d), 0);
        rd_reg(8'h05, d);
        wr_reg(8'h01, 8'h00);
        // R12 snapshot held; R4 bits set during a read survive
        wr_reg(8'h15, 8'h0F);
        pulse(2 * NSRC + 0);
        @(negedge clk); cs = 1; rd = 1; addr = 8'h14;
        @(negedge clk); d = rdata; check(d == 8'h01, "R12 snapshot", int'(d), 1);
        evt[2 * NSRC + 1] = 1'b1;
        @(negedge clk); evt[2 * NSRC + 1] = 1'b0;
        d = rdata; check(d == 8'h01, "R12 snapshot held", int'(d), 1);
        cs = 0; rd = 0;
        @(negedge clk);
        rd_reg(8'h14, d); check(d == 8'h02, "R4 late event survives", int'(d), 2);
        repeat (3) @(negedge clk);
        done = 1;
        report();
    end

endmodule